// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block switches one gated logic domain between powered and unpowered states. A single-cycle pulse on `req_on` or `req_off` starts a timed sequence. The sequence drives the domain's control lines in a fixed order: the main power-switch sleep control, the memory power-down bank controls, the isolation clamp, the domain reset and the domain clock enable. The two directions use different orders.

When powering down, the main switch is put to sleep first, then the memories, then the outputs are clamped. An optional long settle period follows before the clock is gated. When powering up, the order is reversed as far as the memories. After that the reset is held around the release of isolation, and the clock is enabled last.

The timing is set by parameters. `SHORT_WAIT` is the number of cycles between the switch, memory and isolation steps. `LONG_WAIT` is the clock settle time on power-down, and 0 means the domain has no clock settle. `HAS_MAIN` set to 0 builds a domain that has only memory power-down controls. Its sleep and isolation steps become no-ops, but the timing of every step stays the same.

Top module: `dom_pwr_seq`

## Requirements
- R1: After reset the block is powered off. `sleep_o`=HAS_MAIN, `iso_o`=HAS_MAIN, every `mem_pd_o` bit is 1, `dom_rst_o`=1, `clk_en_o`=0, `busy_o`=0 and `powered_o`=0.
- R2: A `req_off` accepted at clock edge k sets sleep at edge k. It sets all memory controls at edge k+SHORT_WAIT and sets isolation at edge k+2*SHORT_WAIT.
- R3: On power-down, `clk_en_o` falls and `dom_rst_o` rises together at edge k+2*SHORT_WAIT+LONG_WAIT. With LONG_WAIT=0 this is the same edge as isolation.
- R4: A `req_on` accepted at edge k clears sleep at edge k and clears all memory controls at edge k+SHORT_WAIT. Reset is (re)asserted at k+2*SHORT_WAIT and isolation is cleared at k+2*SHORT_WAIT+1. Reset is released at k+2*SHORT_WAIT+2 and the clock is enabled at k+2*SHORT_WAIT+3.
- R5: With HAS_MAIN=0, `sleep_o` and `iso_o` are always 0. Memory, reset and clock steps keep the R2–R4 timing.
- R6: Memory controls come in banks of BANK_BITS (2) bits. All bits of all banks always carry the same value.
- R7: `powered_o` is 1 only after a completed power-up and before the next accepted `req_off`. It is 0 whenever `sleep_o` is 1.
- R8: Requests arriving while `busy_o` is 1 are ignored. This includes a request in the cycle of the final step.
- R9: `req_on` while powered and `req_off` while off change no output, and `busy_o` stays 0.
- R10: `busy_o` is 1 from the accepting edge until the edge driving the final step. That is 2*SHORT_WAIT+3 cycles for power-up and 2*SHORT_WAIT+LONG_WAIT cycles for power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_on | input | 1 | Power-up request pulse |
| req_off | input | 1 | Power-down request pulse |
| sleep_o | output | 1 | Main power switch sleep control, 1 = switch off |
| iso_o | output | 1 | Isolation clamp, 1 = clamped |
| mem_pd_o | output | NUM_BANKS*BANK_BITS | Memory bank power-down controls, 1 = powered down |
| dom_rst_o | output | 1 | Domain reset, 1 = asserted |
| clk_en_o | output | 1 | Domain clock enable |
| busy_o | output | 1 | Sequence in progress |
| powered_o | output | 1 | Domain powered and running |

## Verification
The assertions check the following on every cycle:
- memory bits stay uniform;
- powered status excludes sleep and matches a fully running domain;
- isolation is released only under reset, and reset is released only with isolation and memory down;
- isolation and clock gating happen only after the memories are down;
- an idle, unpowered block stays still.

The exact cycle distances between steps, the ignoring of requests during a sequence and at its final step, and the lack of effect of redundant requests can only be shown by the bench scenarios. The bench traces every output cycle by cycle against arithmetic expectations for three parameter sets.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_ON,
    ST_UP_W1,
    ST_UP_W2,
    ST_UP_ISO,
    ST_UP_RLS,
    ST_UP_CLK,
    ST_DN_W1,
    ST_DN_W2,
    ST_DN_SETTLE
  } dps_state_e;

  typedef struct packed {
    logic sleep;
    logic iso;
    logic mem_off;
    logic rst;
    logic clk_en;
  } dps_ctl_t;

endpackage

// File: rtl/dps_rst_sync.sv
module dps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/dps_timer.sv
module dps_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cnt_en,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_we = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_we = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_en && (cnt_q != '0)) begin
      cnt_we = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dps_fsm.sv
module dps_fsm
  import dps_pkg::*;
#(
  parameter bit HAS_MAIN   = 1'b1,
  parameter int CNT_W      = 4,
  parameter int SHORT_WAIT = 4,
  parameter int LONG_WAIT  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_on,
  input  logic             req_off,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             tmr_en,
  output dps_ctl_t         ctl,
  output logic             busy,
  output logic             powered
);

  localparam int SHORT_M1 = (SHORT_WAIT > 0) ? SHORT_WAIT - 1 : 0;
  localparam int LONG_M1  = (LONG_WAIT > 0) ? LONG_WAIT - 1 : 0;
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_M1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_M1);
  localparam dps_ctl_t OFF_CTL = '{sleep: HAS_MAIN, iso: HAS_MAIN,
                                    mem_off: 1'b1, rst: 1'b1, clk_en: 1'b0};

  dps_state_e state_q, state_d;
  dps_ctl_t   ctl_q, ctl_d;
  logic       step_en;

  always_comb begin
    state_d  = state_q;
    ctl_d    = ctl_q;
    tmr_load = 1'b0;
    tmr_val  = SHORT_LD;
    unique case (state_q)
      ST_OFF: if (req_on) begin
        ctl_d.sleep = 1'b0;
        tmr_load    = 1'b1;
        state_d     = ST_UP_W1;
      end
      ST_ON: if (req_off) begin
        ctl_d.sleep = HAS_MAIN;
        tmr_load    = 1'b1;
        state_d     = ST_DN_W1;
      end
      ST_UP_W1: if (tmr_zero) begin
        ctl_d.mem_off = 1'b0;
        tmr_load      = 1'b1;
        state_d       = ST_UP_W2;
      end
      ST_UP_W2: if (tmr_zero) begin
        ctl_d.rst = 1'b1;
        state_d   = ST_UP_ISO;
      end
      ST_UP_ISO: begin
        ctl_d.iso = 1'b0;
        state_d   = ST_UP_RLS;
      end
      ST_UP_RLS: begin
        ctl_d.rst = 1'b0;
        state_d   = ST_UP_CLK;
      end
      ST_UP_CLK: begin
        ctl_d.clk_en = 1'b1;
        state_d      = ST_ON;
      end
      ST_DN_W1: if (tmr_zero) begin
        ctl_d.mem_off = 1'b1;
        tmr_load      = 1'b1;
        state_d       = ST_DN_W2;
      end
      ST_DN_W2: if (tmr_zero) begin
        ctl_d.iso = HAS_MAIN;
        if (LONG_WAIT == 0) begin
          ctl_d.clk_en = 1'b0;
          ctl_d.rst    = 1'b1;
          state_d      = ST_OFF;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = LONG_LD;
          state_d  = ST_DN_SETTLE;
        end
      end
      ST_DN_SETTLE: if (tmr_zero) begin
        ctl_d.clk_en = 1'b0;
        ctl_d.rst    = 1'b1;
        state_d      = ST_OFF;
      end
      default: begin
        ctl_d   = OFF_CTL;
        state_d = ST_OFF;
      end
    endcase
  end

  assign step_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      ctl_q   <= OFF_CTL;
    end else if (step_en) begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

  assign busy    = (state_q != ST_OFF) && (state_q != ST_ON);
  assign powered = (state_q == ST_ON) && !ctl_q.sleep;
  assign tmr_en  = busy;
  assign ctl     = ctl_q;

endmodule

// File: rtl/dom_pwr_seq.sv
module dom_pwr_seq
  import dps_pkg::*;
#(
  parameter bit HAS_MAIN   = 1'b1,
  parameter int NUM_BANKS  = 4,
  parameter int BANK_BITS  = 2,
  parameter int SHORT_WAIT = 2000,
  parameter int LONG_WAIT  = 2000000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_on,
  input  logic                           req_off,
  output logic                           sleep_o,
  output logic                           iso_o,
  output logic [NUM_BANKS*BANK_BITS-1:0] mem_pd_o,
  output logic                           dom_rst_o,
  output logic                           clk_en_o,
  output logic                           busy_o,
  output logic                           powered_o
);

  localparam int MAX_WAIT = (SHORT_WAIT > LONG_WAIT) ? SHORT_WAIT : LONG_WAIT;
  localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT + 1) : 1;

  logic             rst_n_sync;
  logic             tmr_load, tmr_en, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  dps_ctl_t         ctl;

  dps_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt_en   (tmr_en),
    .zero     (tmr_zero)
  );

  dps_fsm #(
    .HAS_MAIN   (HAS_MAIN),
    .CNT_W      (CNT_W),
    .SHORT_WAIT (SHORT_WAIT),
    .LONG_WAIT  (LONG_WAIT)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .req_on   (req_on),
    .req_off  (req_off),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .tmr_en   (tmr_en),
    .ctl      (ctl),
    .busy     (busy_o),
    .powered  (powered_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign mem_pd_o[b*BANK_BITS +: BANK_BITS] = {BANK_BITS{ctl.mem_off}};
  end

  assign sleep_o   = ctl.sleep;
  assign iso_o     = ctl.iso;
  assign dom_rst_o = ctl.rst;
  assign clk_en_o  = ctl.clk_en;

endmodule

// File: rtl/dps_chk.sv
module dps_chk #(
  parameter bit HAS_MAIN = 1'b1,
  parameter int MEM_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_on,
  input logic             sleep_o,
  input logic             iso_o,
  input logic [MEM_W-1:0] mem_pd_o,
  input logic             dom_rst_o,
  input logic             clk_en_o,
  input logic             busy_o,
  input logic             powered_o
);

  // R6
  mem_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_pd_o == '0) || (mem_pd_o == '1));

  // R7
  powered_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !powered_o);

  // R7
  powered_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    powered_o |-> (clk_en_o && !dom_rst_o && !iso_o && (mem_pd_o == '0) && !busy_o));

  // R4
  iso_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_o) |-> dom_rst_o);

  // R4
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_rst_o) |-> (!iso_o && (mem_pd_o == '0) && !sleep_o));

  // R2
  iso_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_o) |-> ((mem_pd_o == '1) && sleep_o));

  // R3
  clk_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_o) |-> ((iso_o == HAS_MAIN) && (mem_pd_o == '1) && dom_rst_o));

  // R5
  no_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_MAIN |-> (!sleep_o && !iso_o));

  // R9
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !powered_o && !req_on) |=>
      ($stable(mem_pd_o) && $stable(clk_en_o) && $stable(dom_rst_o) && !busy_o));

endmodule

bind dom_pwr_seq dps_chk #(
  .HAS_MAIN (HAS_MAIN),
  .MEM_W    (NUM_BANKS*BANK_BITS)
) u_dps_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_on    (req_on),
  .sleep_o   (sleep_o),
  .iso_o     (iso_o),
  .mem_pd_o  (mem_pd_o),
  .dom_rst_o (dom_rst_o),
  .clk_en_o  (clk_en_o),
  .busy_o    (busy_o),
  .powered_o (powered_o)
);

// File: tb/dom_pwr_seq_bench.sv
module dps_harness #(
  parameter bit HM = 1'b1,
  parameter int NB = 2,
  parameter int W  = 2,
  parameter int L  = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   checks,
  output int   fails
);

  localparam int MW = NB * 2;

  logic          req_on, req_off;
  logic          sleep_o, iso_o, dom_rst_o, clk_en_o, busy_o, powered_o;
  logic [MW-1:0] mem_pd_o;

  dom_pwr_seq #(
    .HAS_MAIN (HM), .NUM_BANKS (NB), .BANK_BITS (2),
    .SHORT_WAIT (W), .LONG_WAIT (L)
  ) u_dom_pwr_seq (
    .clk (clk), .rst_n (rst_n), .req_on (req_on), .req_off (req_off),
    .sleep_o (sleep_o), .iso_o (iso_o), .mem_pd_o (mem_pd_o),
    .dom_rst_o (dom_rst_o), .clk_en_o (clk_en_o), .busy_o (busy_o),
    .powered_o (powered_o)
  );

  task automatic chk(input string tag, input int t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s HM=%0d W=%0d L=%0d t=%0d actual=%b expected=%b",
               tag, HM, W, L, t, act, exp);
    end
  endtask

  task automatic cmp(input string ph, input int t, input logic e_sl, input logic e_iso,
                     input logic e_mem, input logic e_rst, input logic e_clk,
                     input logic e_busy, input logic e_pw);
    string mt;
    mt = HM ? ph : "R5";
    chk({mt, " sleep"}, t, sleep_o, e_sl);
    chk({mt, " iso"}, t, iso_o, e_iso);
    chk({ph, " mem"}, t, mem_pd_o[0], e_mem);
    chk("R6 mem uniform", t, (mem_pd_o == {MW{mem_pd_o[0]}}), 1'b1);
    chk({ph, " rst"}, t, dom_rst_o, e_rst);
    chk({ph, " clk_en"}, t, clk_en_o, e_clk);
    chk("R10 busy", t, busy_o, e_busy);
    chk("R7 powered", t, powered_o, e_pw);
  endtask

  initial begin
    int eu, ed;
    eu = 2*W + 3;
    ed = 2*W + L;
    done = 1'b0; checks = 0; fails = 0;
    req_on = 1'b0; req_off = 1'b0;
    @(negedge clk);
    // R1 state while reset is held
    cmp("R1", -1, HM, HM, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    wait (rst_n === 1'b1);
    repeat (4) @(negedge clk);
    cmp("R1", 0, HM, HM, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int rep = 0; rep < 2; rep++) begin
      // R9 redundant off request while off
      req_off = 1'b1; @(negedge clk); req_off = 1'b0;
      for (int t = 0; t < 4; t++) begin
        cmp("R9", t, HM, HM, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
      end
      // power-up trace; R8 pulses at t=1 and in final step cycle
      req_on = 1'b1; @(negedge clk); req_on = 1'b0;
      for (int t = 0; t <= eu + 3; t++) begin
        cmp((t > 1) ? "R4 R8" : "R4", t, 1'b0, (t < 2*W+1) ? HM : 1'b0, (t < W),
            (t < 2*W+2), (t >= eu), (t < eu), (t >= eu));
        req_off = (t == 1) || (t == eu - 1);
        @(negedge clk);
      end
      req_off = 1'b0;
      // R9 redundant on request while powered
      req_on = 1'b1; @(negedge clk); req_on = 1'b0;
      for (int t = 0; t < 4; t++) begin
        cmp("R9", t, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
      end
      // power-down trace; R3 clock/reset timing, R8 pulses
      req_off = 1'b1; @(negedge clk); req_off = 1'b0;
      for (int t = 0; t <= ed + 3; t++) begin
        cmp((t < 2*W) ? "R2" : "R2 R3 R8", t, HM, (t >= 2*W) ? HM : 1'b0, (t >= W),
            (t >= ed), (t < ed), (t < ed), 1'b0);
        req_on = (t == 1) || ((t == ed - 1) && (ed > 2));
        @(negedge clk);
      end
      req_on = 1'b0;
    end
    done = 1'b1;
  end

endmodule

module dom_pwr_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic clk, rst_n;
  logic d0, d1, d2;
  int   c0, c1, c2, f0, f1, f2;
  int   wd_fail;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  dps_harness #(.HM(1'b1), .NB(3), .W(3), .L(5)) u_main (
    .clk (clk), .rst_n (rst_n), .done (d0), .checks (c0), .fails (f0));
  dps_harness #(.HM(1'b0), .NB(2), .W(2), .L(0)) u_memonly (
    .clk (clk), .rst_n (rst_n), .done (d1), .checks (c1), .fails (f1));
  dps_harness #(.HM(1'b1), .NB(1), .W(1), .L(0)) u_short (
    .clk (clk), .rst_n (rst_n), .done (d2), .checks (c2), .fails (f2));

  initial begin
    wd_fail = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4) rst_n = 1'b1;
    for (int c = 0; c < WD_CYCLES; c++) begin
      @(posedge clk);
      if (d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) break;
    end
    if (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1)) begin
      wd_fail = 1;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    #1;
    $display("TB_RESULT checks=%0d failures=%0d",
             c0 + c1 + c2 + wd_fail, f0 + f1 + f2 + wd_fail);
    $finish;
  end

endmodule